// File: doc/BRIEF.md
# Filter Program Sequencer

This block steps a filter compute engine through a microprogram of up to 32 steps. Each step is a 128-bit word held in an internal instruction store. A host loads the store through a write port while the sequencer is halted. In every executed step the sequencer decodes the low nine bits of the word as one of several control operations:

- wait for enough input samples
- unconditional jump
- jump on resampler carry
- jump on no resampler carry
- no-operation
- loop-counter load

Any other word is a compute step. The whole word goes to the external datapath together with a one-cycle issue strobe and the decoded coefficient block step, and the sequencer then holds until the datapath reports completion.

A free-running counter tracks how many input samples are available. It rises by one for each `sample_in` strobe and saturates at its maximum. A wait step holds the program counter until that count is strictly greater than `wait_thresh`, which is normally set to the decimation factor. When the wait completes, the threshold is subtracted from the count.

The controller has three states:

| State | Meaning | Transitions |
|---|---|---|
| HALT | Idle; writes to the store are accepted | To RUN when `run` is 1 |
| RUN | Executes one step per cycle | To HALT when `run` is 0; to BUSY after issuing a compute step |
| BUSY | Holds while the datapath computes | When `compute_done` arrives: to RUN if `run` is 1, otherwise to HALT |

Top module: `filt_seq`

## Requirements
- R1: After reset the following hold: state HALT, `pc` = 0, `compute_issue` = 0, `avail_count` = 0, `loop_count` = 0 and `loop_zero` = 1.
- R2: A write to the instruction store takes effect only in HALT. A write made while in RUN or BUSY is ignored.
- R3: A wait step (bits 8:0 = 9'h001) holds `pc` while `avail_count` <= `wait_thresh`. Once `avail_count` > `wait_thresh`, it advances `pc` by one and lowers `avail_count` by `wait_thresh`.
- R4: Each cycle with `sample_in` = 1 raises `avail_count` by one. At its all-ones maximum the count saturates.
- R5: When bit 8 = 1 and bits 2:0 = 3'b111, `pc` is loaded with bits 7:3 (unconditional jump).
- R6: When bit 8 = 1 and bits 2:0 = 3'b101, the jump to bits 7:3 is taken only if `nco_carry` = 1. When bits 2:0 = 3'b100, it is taken only if `nco_carry` = 0. When the condition is false, `pc` advances by one.
- R7: A no-op step (bits 8:0 = 9'h080) advances `pc` by one and changes nothing else.
- R8: A load step (bits 8:0 = 9'h084) copies bits 20:9 into `loop_count` and advances `pc`. For example, word 0x1C84 loads 14. `loop_zero` is 1 exactly when `loop_count` is 0.
- R9: Any other word is a compute step. It drives `compute_issue` high for exactly one cycle, with `instr_out` equal to the word. `pc` then holds until `compute_done`, and advances by one in the cycle after `compute_done`.
- R10: `coef_step` is given with each compute issue and is decoded from bits 125:123. Code 0 gives 0, and code n (1 to 7) gives 2^(n-1), so the values are 0, 1, 2, 4, 8, 16, 32 and 64.
- R11: Advancing from step 31 wraps `pc` to 0.
- R12: When `run` = 0 in RUN, or while in HALT, no step executes: `pc` and `loop_count` stay unchanged and `compute_issue` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 lets the program execute; 0 halts it |
| wr_en | input | 1 | Instruction store write strobe (honoured only in HALT) |
| wr_addr | input | 5 | Instruction store write address |
| wr_data | input | 128 | Instruction word to store |
| sample_in | input | 1 | One new input sample this cycle |
| wait_thresh | input | CNT_W | Threshold used by wait steps |
| nco_carry | input | 1 | Resampler carry, the condition for conditional jumps |
| compute_done | input | 1 | Datapath has finished the issued compute step |
| compute_issue | output | 1 | One-cycle strobe for a compute step |
| instr_out | output | 128 | Instruction word of the issued compute step |
| coef_step | output | 7 | Decoded coefficient block step |
| pc | output | 5 | Program counter |
| loop_count | output | 12 | Loop counter |
| loop_zero | output | 1 | Loop counter equals zero |
| avail_count | output | CNT_W | Available input samples |

## Verification
The assertions assume that `compute_done` is asserted only in the BUSY state, and that `wait_thresh` and `nco_carry` stay steady while a step that reads them executes. They also assume that no store write is aimed at the step currently under execution in HALT. The stimulus respects these assumptions:

- All inputs are changed on the falling edge.
- `compute_done` is pulsed only after an observed issue.
- The threshold and carry are set before `run` is raised.
- Store writes used to set up a program happen only after `run` has dropped and the halt has taken effect. The one deliberate exception is the write made during RUN to show that it is ignored.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    localparam int IW     = 128;
    localparam int AW     = 5;
    localparam int DEPTH  = 1 << AW;
    localparam int LOOP_W = 12;
    localparam int STEP_W = 7;
    localparam int CODE_W = 3;
    localparam int CTL_W  = 21;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_RUN,
        ST_BUSY
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_WAIT,
        OP_JMP,
        OP_JC,
        OP_JNC,
        OP_NOP,
        OP_LOAD,
        OP_COMP
    } op_e;

    localparam logic [8:0] ENC_WAIT = 9'h001;
    localparam logic [8:0] ENC_NOP  = 9'h080;
    localparam logic [8:0] ENC_LOAD = 9'h084;
    localparam logic [2:0] JK_ALWAYS  = 3'b111;
    localparam logic [2:0] JK_CARRY   = 3'b101;
    localparam logic [2:0] JK_NOCARRY = 3'b100;
endpackage

// File: rtl/fseq_imem.sv
module fseq_imem
    import fseq_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
    import fseq_pkg::*;
(
    input  logic [CTL_W-1:0]  ctl,
    input  logic [CODE_W-1:0] step_code,
    output op_e               op,
    output logic [AW-1:0]     target,
    output logic [LOOP_W-1:0] loop_val,
    output logic [STEP_W-1:0] step
);
    always_comb begin
        if (ctl[8:0] == ENC_WAIT) begin
            op = OP_WAIT;
        end else if (ctl[8]) begin
            unique case (ctl[2:0])
                JK_ALWAYS:  op = OP_JMP;
                JK_CARRY:   op = OP_JC;
                JK_NOCARRY: op = OP_JNC;
                default:    op = OP_COMP;
            endcase
        end else if (ctl[8:0] == ENC_NOP) begin
            op = OP_NOP;
        end else if (ctl[8:0] == ENC_LOAD) begin
            op = OP_LOAD;
        end else begin
            op = OP_COMP;
        end
    end

    assign target   = ctl[7:3];
    assign loop_val = ctl[20:9];

    always_comb begin
        if (step_code == '0) begin
            step = '0;
        end else begin
            step = STEP_W'(1) << (step_code - CODE_W'(1));
        end
    end

    // R10: the decoded step is zero or a single power of two
    always_comb begin
        p_step_pow2_r10: assert ($onehot0(step));
    end
endmodule

// File: rtl/fseq_avail.sv
module fseq_avail #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             take,
    input  logic [CNT_W-1:0] amount,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] after_take;

    always_comb begin
        after_take = take ? (count - amount) : count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && after_take != CNT_MAX) begin
            count <= after_take + CNT_ONE;
        end else begin
            count <= after_take;
        end
    end

    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && inc && !take) |=> (count == CNT_MAX));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != CNT_MAX && inc && !take) |=> (count == $past(count) + CNT_ONE));
endmodule

// File: rtl/filt_seq.sv
module filt_seq
    import fseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [127:0]      wr_data,
    input  logic              sample_in,
    input  logic [CNT_W-1:0]  wait_thresh,
    input  logic              nco_carry,
    input  logic              compute_done,
    output logic              compute_issue,
    output logic [127:0]      instr_out,
    output logic [6:0]        coef_step,
    output logic [4:0]        pc,
    output logic [11:0]       loop_count,
    output logic              loop_zero,
    output logic [CNT_W-1:0]  avail_count
);
    localparam logic [AW-1:0] PC_ONE  = AW'(1);
    localparam logic [AW-1:0] PC_LAST = AW'(DEPTH - 1);

    seq_state_e        state, state_nxt;
    logic [IW-1:0]     cur_word;
    op_e               op;
    logic [AW-1:0]     target;
    logic [LOOP_W-1:0] loop_val;
    logic [STEP_W-1:0] step_dec;
    logic              exec;
    logic              ready;
    logic              take;
    logic [AW-1:0]     pc_nxt;

    fseq_imem u_imem (
        .clk   (clk),
        .we    (wr_en && state == ST_HALT),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (pc),
        .rdata (cur_word)
    );

    fseq_decode u_dec (
        .ctl       (cur_word[CTL_W-1:0]),
        .step_code (cur_word[125:123]),
        .op        (op),
        .target    (target),
        .loop_val  (loop_val),
        .step      (step_dec)
    );

    fseq_avail #(.CNT_W(CNT_W)) u_avail (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (sample_in),
        .take   (take),
        .amount (wait_thresh),
        .count  (avail_count)
    );

    assign exec  = (state == ST_RUN) && run;
    assign ready = avail_count > wait_thresh;
    assign take  = exec && (op == OP_WAIT) && ready;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT: state_nxt = run ? ST_RUN : ST_HALT;
            ST_RUN: begin
                if (!run) begin
                    state_nxt = ST_HALT;
                end else if (op == OP_COMP) begin
                    state_nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (compute_done) begin
                    state_nxt = run ? ST_RUN : ST_HALT;
                end
            end
            default: state_nxt = ST_HALT;
        endcase
    end

    // program counter selection
    always_comb begin
        pc_nxt = pc;
        if (exec) begin
            unique case (op)
                OP_WAIT: pc_nxt = ready ? pc + PC_ONE : pc;
                OP_JMP:  pc_nxt = target;
                OP_JC:   pc_nxt = nco_carry ? target : pc + PC_ONE;
                OP_JNC:  pc_nxt = nco_carry ? pc + PC_ONE : target;
                OP_NOP,
                OP_LOAD: pc_nxt = pc + PC_ONE;
                OP_COMP: pc_nxt = pc;
                default: pc_nxt = pc;
            endcase
        end else if (state == ST_BUSY && compute_done) begin
            pc_nxt = pc + PC_ONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc            <= '0;
            loop_count    <= '0;
            compute_issue <= 1'b0;
            instr_out     <= '0;
            coef_step     <= '0;
        end else begin
            pc            <= pc_nxt;
            compute_issue <= exec && (op == OP_COMP);
            if (exec && op == OP_LOAD) begin
                loop_count <= loop_val;
            end
            if (exec && op == OP_COMP) begin
                instr_out <= cur_word;
                coef_step <= step_dec;
            end
        end
    end

    assign loop_zero = (loop_count == '0);

    p_issue_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        compute_issue |=> !compute_issue);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !compute_done) |=> $stable(pc));

    p_halt_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> ($stable(pc) && $stable(loop_count) && !compute_issue));

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_WAIT && !ready) |=> $stable(pc));

    p_uncond_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_JMP) |=> (pc == $past(target)));

    p_pc_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_NOP && pc == PC_LAST) |=> (pc == '0));

    p_loop_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LOAD) |=> (loop_count == $past(loop_val)));
endmodule

// File: tb/filt_seq_bench.sv
module filt_seq_bench;
    localparam int CNT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [127:0]      wr_data = '0;
    logic              sample_in = 1'b0;
    logic [CNT_W-1:0]  wait_thresh = '0;
    logic              nco_carry = 1'b0;
    logic              compute_done = 1'b0;
    logic              compute_issue;
    logic [127:0]      instr_out;
    logic [6:0]        coef_step;
    logic [4:0]        pc;
    logic [11:0]       loop_count;
    logic              loop_zero;
    logic [CNT_W-1:0]  avail_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    filt_seq #(.CNT_W(CNT_W)) u_filt_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .sample_in    (sample_in),
        .wait_thresh  (wait_thresh),
        .nco_carry    (nco_carry),
        .compute_done (compute_done),
        .compute_issue(compute_issue),
        .instr_out    (instr_out),
        .coef_step    (coef_step),
        .pc           (pc),
        .loop_count   (loop_count),
        .loop_zero    (loop_zero),
        .avail_count  (avail_count)
    );

    // vector: {ctl[20:0], carry, expected pc[4:0], expected loop[11:0]}
    localparam int NV = 9;
    localparam logic [38:0] VEC [NV] = '{
        {21'h00014F, 1'b0, 5'd9,  12'd0},    // R5 jump always to 9
        {21'h00013D, 1'b1, 5'd7,  12'd0},    // R6 carry set, taken
        {21'h00013D, 1'b0, 5'd1,  12'd0},    // R6 carry clear, fall through
        {21'h000164, 1'b0, 5'd12, 12'd0},    // R6 no-carry kind, taken
        {21'h000164, 1'b1, 5'd1,  12'd0},    // R6 no-carry kind, fall through
        {21'h000080, 1'b0, 5'd1,  12'd0},    // R7 no-op
        {21'h001C84, 1'b0, 5'd1,  12'd14},   // R8 load 14
        {21'h1FFE84, 1'b0, 5'd1,  12'd4095}, // R8 load max
        {21'h000001, 1'b0, 5'd0,  12'd0}     // R3 wait with nothing available
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        run = 1'b0; wr_en = 1'b0; sample_in = 1'b0; compute_done = 1'b0;
        nco_carry = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic [4:0] a, input logic [127:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [127:0] comp_word(input logic [2:0] code);
        return {2'b00, code, 114'd0, 9'h0C8};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pc", pc, 0);
        chk("R1 issue", compute_issue, 0);
        chk("R1 avail", avail_count, 0);
        chk("R1 loop", loop_count, 0);
        chk("R1 loop_zero", loop_zero, 1);

        // table walk: one control step executed from step 0
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wait_thresh = 8'd2;
            wr(5'd0, {107'd0, VEC[i][38:18]});
            nco_carry = VEC[i][17];
            run = 1'b1;
            step();            // HALT -> RUN
            step();            // execute step 0
            run = 1'b0;
            step();            // RUN -> HALT
            chk("R5/R6/R7/R8/R3 table pc", pc, VEC[i][16:12]);
            chk("R8 table loop", loop_count, VEC[i][11:0]);
            chk("R8 table loop_zero", loop_zero, VEC[i][11:0] == 12'd0);
        end

        // R10 step decode for every code
        for (int c = 0; c < 8; c++) begin
            do_reset();
            wr(5'd0, comp_word(3'(c)));
            run = 1'b1;
            step(); step();
            chk("R10 issue", compute_issue, 1);
            chk("R10 coef_step", coef_step, (c == 0) ? 0 : (1 << (c - 1)));
            run = 1'b0;
            step();
        end

        // R3/R9/R5 minimal program: wait, compute, jump 0
        do_reset();
        wait_thresh = 8'd2;
        wr(5'd0, 128'h001);
        wr(5'd1, comp_word(3'd3));
        wr(5'd2, 128'h107);
        sample_in = 1'b1;
        step(); step(); step();
        sample_in = 1'b0;
        chk("R4 three samples", avail_count, 3);
        run = 1'b1;
        step();
        step();
        chk("R3 wait done pc", pc, 1);
        chk("R3 wait consumes", avail_count, 1);
        step();
        chk("R9 issue high", compute_issue, 1);
        chk("R9 instr_out", instr_out, comp_word(3'd3));
        chk("R10 step code 3", coef_step, 4);
        step();
        chk("R9 issue one cycle", compute_issue, 0);
        chk("R9 hold pc", pc, 1);
        compute_done = 1'b1;
        step();
        compute_done = 1'b0;
        chk("R9 advance after done", pc, 2);
        step();
        chk("R5 jump back", pc, 0);
        step();
        chk("R3 hold below threshold", pc, 0);
        sample_in = 1'b1;
        step();
        sample_in = 1'b0;
        step();
        chk("R3 equal is not enough", pc, 0);
        chk("R4 count two", avail_count, 2);
        sample_in = 1'b1;
        step();
        sample_in = 1'b0;
        step();
        chk("R3 proceeds above threshold", pc, 1);
        chk("R3 consumed again", avail_count, 1);
        run = 1'b0;
        step();

        // R2 write while running is ignored
        do_reset();
        wait_thresh = 8'd2;
        wr(5'd0, 128'h001);
        run = 1'b1;
        step();
        wr(5'd0, 128'h080);
        step();
        chk("R2 running write ignored", pc, 0);
        run = 1'b0;
        step();
        run = 1'b1;
        step(); step();
        chk("R2 store still holds wait", pc, 0);
        run = 1'b0;
        step();

        // R11 wrap and R12 halt
        do_reset();
        wr(5'd0, 128'h1FF);
        wr(5'd31, 128'h080);
        run = 1'b1;
        step();
        step();
        chk("R5 jump to 31", pc, 31);
        run = 1'b0;
        step();
        repeat (4) step();
        chk("R12 pc frozen", pc, 31);
        chk("R12 no issue", compute_issue, 0);
        run = 1'b1;
        step();
        step();
        chk("R11 wrap to 0", pc, 0);
        run = 1'b0;
        step();

        // R4 saturation
        do_reset();
        sample_in = 1'b1;
        repeat (300) step();
        sample_in = 1'b0;
        chk("R4 saturate", avail_count, 255);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule